// File: doc/BRIEF.md
# Write-only two-wire slave receiver

This block is the receive side of a two-wire serial slave for a small peripheral that is only ever written to. It oversamples the open-drain clock and data lines with the fast system clock and cleans them with a synchronizer and a three-sample majority filter. It then recognises the start and stop conditions and shifts in bytes, most significant bit first, on rising clock edges.

The first byte of a transfer is compared with two addresses. One is the device's own address: a fixed upper nibble of 0100, with the low three bits taken from strap inputs. The other is a broadcast sync address that every device on the bus shares. When an address matches, the block acknowledges by pulling the data line low for the ninth clock. For its own address it then accepts any number of data bytes and reports each one as a single-cycle pulse that carries the byte and its position in the transfer. For the sync address the eighth bit is a flag, not a direction bit. The block reports that flag with a pulse at the rising clock edge of the acknowledge. Storing the bytes and acting on them is left to the logic around the block.

Top module: `smbus_wr_slave`

## Requirements
- R1: After reset, sda_oe, start_p, stop_p, byte_p and sync_p are all 0.
- R2: A falling data line while the clock is high gives a one-cycle start_p. A rising data line while the clock is high gives a one-cycle stop_p. Each pulse appears 6 clock cycles after the line change that forms the condition.
- R3: A low or high excursion of one system-clock sample on either line has no effect: it produces no start_p, no stop_p and no received bit.
- R4: An address byte equal to {0100, strap_i[2], strap_i[1], strap_i[0], 0} is acknowledged. sda_oe (1 = pull data low) rises on the clock fall after the eighth bit and falls on the clock fall after the ninth, and it does not change while the clock is high.
- R5: An address byte that matches neither address, or the own address with the eighth bit at 1, is not acknowledged. Later bytes produce no byte_p and no acknowledge until the next START.
- R6: Each data byte that follows an acknowledged own address produces byte_p on its eighth rising clock, with byte_data holding the byte (first bit received in bit 7) and byte_idx counting 0, 1, 2, and so on. Every such byte is acknowledged.
- R7: byte_idx restarts at 0 after every START. A repeated START restarts address matching without a stop_p.
- R8: An address byte whose upper seven bits are 1111110 is acknowledged whatever its eighth bit is. sync_p pulses at the rising clock of that acknowledge, with sync_bit equal to the eighth bit. Later bytes in the same transfer are ignored.
- R9: A STOP in the middle of a byte abandons it with no byte_p, sends the block idle, and leaves it ready for the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Low three bits of the own address |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| start_p | output | 1 | START detected, one cycle |
| stop_p | output | 1 | STOP detected, one cycle |
| byte_p | output | 1 | Data byte received, one cycle |
| byte_data | output | 8 | Last received data byte |
| byte_idx | output | IDX_W | Position of that byte after the address |
| sync_p | output | 1 | Sync command acknowledged, one cycle |
| sync_bit | output | 1 | Flag bit that came with the sync address |

## Verification
The assertions assume a well-behaved master. It changes the data line only while the clock is low, except when it is forming a START or STOP. It holds each level for several filter samples, and it never drives data while the slave acknowledges. The bench keeps to these assumptions by generating every bus phase from half-periods of 20 system cycles and changing the master's lines only on falling system-clock edges. Its only deliberate breaks of the rule are single-cycle glitches, which the filter is required to reject.

// File: rtl/smbus_wr_slave.sv
module smbus_wr_slave #(
  parameter logic [3:0] ADDR_HI   = 4'b0100,
  parameter logic [6:0] SYNC_ADDR = 7'b1111110,
  parameter int         IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       strap_i,
  output logic             sda_oe,
  output logic             start_p,
  output logic             stop_p,
  output logic             byte_p,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             sync_p,
  output logic             sync_bit
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_IGN} st_t;

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      scl_f <= (scl_h[0] & scl_h[1]) | (scl_h[1] & scl_h[2]) | (scl_h[0] & scl_h[2]);
      sda_f <= (sda_h[0] & sda_h[1]) | (sda_h[1] & sda_h[2]) | (sda_h[0] & sda_h[2]);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t             st;
  logic [3:0]      cnt;
  logic [6:0]      sr;
  logic            ack_en, sync_hit;
  logic [IDX_W-1:0] idx;

  wire [7:0] rx_byte = {sr, sda_f};
  wire own_hit  = (rx_byte[7:1] == {ADDR_HI, strap_i}) && !rx_byte[0];
  wire sync_hit_c = (rx_byte[7:1] == SYNC_ADDR);
  wire active   = (st == ST_ADDR) || (st == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; ack_en <= 1'b0; sync_hit <= 1'b0;
      idx <= '0; sda_oe <= 1'b0; start_p <= 1'b0; stop_p <= 1'b0;
      byte_p <= 1'b0; byte_data <= '0; byte_idx <= '0; sync_p <= 1'b0; sync_bit <= 1'b0;
    end else begin
      start_p <= 1'b0; stop_p <= 1'b0; byte_p <= 1'b0; sync_p <= 1'b0;
      if (start_c) begin
        start_p <= 1'b1; st <= ST_ADDR; cnt <= '0; idx <= '0;
        sda_oe <= 1'b0; ack_en <= 1'b0; sync_hit <= 1'b0;
      end else if (stop_c) begin
        stop_p <= 1'b1; st <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0; ack_en <= 1'b0;
      end else if (active && scl_rise) begin
        if (cnt != 4'd8) begin
          sr  <= rx_byte[6:0];
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            if (st == ST_ADDR) begin
              ack_en   <= own_hit | sync_hit_c;
              sync_hit <= sync_hit_c;
              sync_bit <= rx_byte[0];
            end else begin
              byte_p    <= 1'b1;
              byte_data <= rx_byte;
              byte_idx  <= idx;
              idx       <= idx + 1'b1;
              ack_en    <= 1'b1;
            end
          end
        end else begin
          cnt <= '0;
          if (st == ST_ADDR) begin
            sync_p <= sync_hit & ack_en;
            st     <= (ack_en && !sync_hit) ? ST_DATA : ST_IGN;
          end
        end
      end else if (scl_fall) begin
        if (active && cnt == 4'd8 && ack_en) sda_oe <= 1'b1;
        else if (cnt == 4'd0)                 sda_oe <= 1'b0;
      end
    end
  end

  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_p, stop_p, byte_p, sync_p}));

  a_r4_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_f |=> $stable(sda_oe));

  a_r6_byte_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    byte_p |-> !sda_oe);

  a_r8_sync_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sync_p |-> sda_oe);

  a_r9_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |-> !sda_oe);

endmodule

// File: tb/smbus_wr_slave_tb_top.sv
module smbus_wr_slave_tb_top;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, start_p, stop_p, byte_p, sync_p, sync_bit;
  logic [7:0] byte_data;
  logic [3:0] byte_idx;

  wire scl_ln = scl_m & ~g_scl;
  wire sda_ln = sda_m & ~sda_oe & ~g_sda;

  smbus_wr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln), .strap_i(strap),
    .sda_oe(sda_oe), .start_p(start_p), .stop_p(stop_p), .byte_p(byte_p),
    .byte_data(byte_data), .byte_idx(byte_idx), .sync_p(sync_p), .sync_bit(sync_bit));

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit maj(input bit a, input bit b, input bit c);
    return (a && b) || (b && c) || (a && c);
  endfunction

  // behavioural reference model
  bit hc[8], hd[8];
  int mst, mcnt, mval, mack, msy, midx;
  bit e_start, e_stop, e_byte, e_sync, e_oe;
  int e_data, e_idx, e_sbit;

  always @(posedge clk) begin
    bit cs, ps, cd, pd;
    if (!rst_n) begin
      for (int j = 0; j < 8; j++) begin hc[j] = 1'b1; hd[j] = 1'b1; end
      mst = 0; mcnt = 0; mval = 0; mack = 0; msy = 0; midx = 0;
      e_start = 0; e_stop = 0; e_byte = 0; e_sync = 0; e_oe = 0;
      e_data = 0; e_idx = 0; e_sbit = 0;
    end else begin
      for (int j = 7; j > 0; j--) begin hc[j] = hc[j-1]; hd[j] = hd[j-1]; end
      hc[0] = scl_ln; hd[0] = sda_ln;
      cs = maj(hc[4], hc[5], hc[6]); ps = maj(hc[5], hc[6], hc[7]);
      cd = maj(hd[4], hd[5], hd[6]); pd = maj(hd[5], hd[6], hd[7]);
      e_start = 0; e_stop = 0; e_byte = 0; e_sync = 0;
      if (cs && ps && pd && !cd) begin
        e_start = 1; mst = 1; mcnt = 0; midx = 0; e_oe = 0; mack = 0; msy = 0;
      end else if (cs && ps && !pd && cd) begin
        e_stop = 1; mst = 0; mcnt = 0; e_oe = 0; mack = 0;
      end else if (cs && !ps && (mst == 1 || mst == 2)) begin
        if (mcnt < 8) begin
          mval = (mval * 2 + int'(cd)) % 256;
          mcnt++;
          if (mcnt == 8) begin
            if (mst == 1) begin
              msy = (mval / 2 == 126);
              mack = msy || (mval == 64 + 2 * int'(strap));
              e_sbit = mval % 2;
            end else begin
              e_byte = 1; e_data = mval; e_idx = midx % 16; midx++; mack = 1;
            end
          end
        end else begin
          mcnt = 0;
          if (mst == 1) begin
            e_sync = (msy != 0) && (mack != 0);
            mst = (mack != 0 && msy == 0) ? 2 : 3;
          end
        end
      end else if (!cs && ps) begin
        if ((mst == 1 || mst == 2) && mcnt == 8 && mack != 0) e_oe = 1;
        else if (mcnt == 0) e_oe = 0;
      end
    end
  end

  // observation and per-cycle comparison
  int q_data[$], q_idx[$];
  int n_start = 0, n_stop = 0, n_sync = 0, last_sbit = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk({start_p, stop_p} == {e_start, e_stop}, "R2 start/stop pulses",
          int'({start_p, stop_p}), int'({e_start, e_stop}));
      chk(sda_oe == e_oe, "R4 sda_oe per cycle", int'(sda_oe), int'(e_oe));
      chk(byte_p == e_byte && (!byte_p || (byte_data == e_data[7:0] && byte_idx == e_idx[3:0])),
          "R6 byte pulse", int'({byte_p, byte_data, byte_idx}), (int'(e_byte) << 12) + e_data * 16 + e_idx);
      chk(sync_p == e_sync && (!sync_p || sync_bit == e_sbit[0]), "R8 sync pulse",
          int'({sync_p, sync_bit}), int'(e_sync) * 2 + e_sbit);
      if (start_p) n_start++;
      if (stop_p) n_stop++;
      if (sync_p) begin n_sync++; last_sbit = int'(sync_bit); end
      if (byte_p) begin q_data.push_back(int'(byte_data)); q_idx.push_back(int'(byte_idx)); end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start();
    sda_m = 1'b1; wait_n(H/2); scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H); scl_m = 1'b0; wait_n(H/2);
  endtask

  task automatic send_stop();
    sda_m = 1'b0; wait_n(H/2); scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wait_n(H/2); scl_m = 1'b1; wait_n(H); scl_m = 1'b0; wait_n(H/2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_n(H/2); scl_m = 1'b1; wait_n(H/2);
    ack = ~sda_ln; wait_n(H/2); scl_m = 1'b0; wait_n(H/2);
  endtask

  task automatic expect_bytes(input string tag, input int d[], input int ix[]);
    chk(q_data.size() == d.size(), tag, q_data.size(), d.size());
    for (int i = 0; i < d.size() && i < q_data.size(); i++) begin
      chk(q_data[i] == d[i], tag, q_data[i], d[i]);
      chk(q_idx[i] == ix[i], tag, q_idx[i], ix[i]);
    end
    q_data.delete(); q_idx.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    int s0, p0;
    wait_n(5);
    // R1 reset state
    chk({sda_oe, start_p, stop_p, byte_p, sync_p} == 5'b0, "R1 reset outputs",
        int'({sda_oe, start_p, stop_p, byte_p, sync_p}), 0);
    rst_n = 1'b1;
    wait_n(20);

    // R3 single-sample glitches while idle
    s0 = n_start; p0 = n_stop;
    g_sda = 1'b1; wait_n(1); g_sda = 1'b0; wait_n(15);
    g_scl = 1'b1; wait_n(1); g_scl = 1'b0; wait_n(15);
    chk(n_start == s0 && n_stop == p0, "R3 glitch ignored", n_start + n_stop, s0 + p0);

    // R4 R6 write to own address 0100101
    send_start();
    chk(n_start == s0 + 1, "R2 start seen", n_start, s0 + 1);
    send_byte(8'h4A, ack); chk(ack, "R4 own address acked", int'(ack), 1);
    send_byte(8'h3C, ack); chk(ack, "R6 data acked", int'(ack), 1);
    // R3 SCL glitch low during a data bit high phase
    sda_m = 1'b1; wait_n(H/2); scl_m = 1'b1; wait_n(H/2);
    g_scl = 1'b1; wait_n(1); g_scl = 1'b0; wait_n(H/2); scl_m = 1'b0; wait_n(H/2);
    for (int i = 6; i >= 0; i--) send_bit(8'hA5 >> i);
    sda_m = 1'b1; wait_n(H/2); scl_m = 1'b1; wait_n(H/2);
    ack = ~sda_ln; wait_n(H/2); scl_m = 1'b0; wait_n(H/2);
    chk(ack, "R3 glitch bit count", int'(ack), 1);
    send_stop();
    chk(n_stop == p0 + 1, "R2 stop seen", n_stop, p0 + 1);
    expect_bytes("R6 bytes", '{8'h3C, 8'hA5}, '{0, 1});
    wait_n(40);

    // R5 read bit set on own address
    send_start();
    send_byte(8'h4B, ack); chk(!ack, "R5 read not acked", int'(ack), 0);
    send_byte(8'h11, ack); chk(!ack, "R5 later byte ignored", int'(ack), 0);
    send_stop();
    // R5 foreign address
    send_start();
    send_byte(8'h40, ack); chk(!ack, "R5 foreign not acked", int'(ack), 0);
    send_byte(8'h22, ack); chk(!ack, "R5 foreign byte ignored", int'(ack), 0);
    send_stop();
    expect_bytes("R5 no bytes", '{}, '{});
    wait_n(40);

    // R7 repeated start
    p0 = n_stop;
    send_start();
    send_byte(8'h4A, ack); send_byte(8'h01, ack); send_byte(8'h07, ack);
    send_start();
    chk(n_stop == p0, "R7 no stop on repeated start", n_stop, p0);
    send_byte(8'h4A, ack); chk(ack, "R7 rematch acked", int'(ack), 1);
    send_byte(8'h02, ack);
    send_stop();
    expect_bytes("R7 index restart", '{8'h01, 8'h07, 8'h02}, '{0, 1, 0});
    wait_n(40);

    // R8 sync with flag 1 then 0
    s0 = n_sync;
    send_start();
    send_byte(8'hFD, ack); chk(ack, "R8 sync acked", int'(ack), 1);
    chk(n_sync == s0 + 1 && last_sbit == 1, "R8 sync flag 1", last_sbit, 1);
    send_byte(8'h55, ack); chk(!ack, "R8 after sync ignored", int'(ack), 0);
    send_stop();
    send_start();
    send_byte(8'hFC, ack); chk(ack, "R8 sync acked flag 0", int'(ack), 1);
    chk(n_sync == s0 + 2 && last_sbit == 0, "R8 sync flag 0", last_sbit, 0);
    send_stop();
    expect_bytes("R8 no bytes", '{}, '{});
    wait_n(40);

    // R9 stop in the middle of a data byte
    send_start();
    send_byte(8'h4A, ack);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    send_stop();
    expect_bytes("R9 partial dropped", '{}, '{});
    send_start();
    send_byte(8'h4A, ack); chk(ack, "R9 ready after abort", int'(ack), 1);
    send_byte(8'hC3, ack);
    send_stop();
    expect_bytes("R9 next transfer", '{8'hC3}, '{0});
    wait_n(40);

    // R4 strap change moves the own address
    strap = 3'b010;
    wait_n(10);
    send_start();
    send_byte(8'h4A, ack); chk(!ack, "R4 old address rejected", int'(ack), 0);
    send_stop();
    send_start();
    send_byte(8'h44, ack); chk(ack, "R4 new address acked", int'(ack), 1);
    send_byte(8'h99, ack);
    send_stop();
    expect_bytes("R4 strap bytes", '{8'h99}, '{0});
    wait_n(40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule